// File: doc/BRIEF.md
# Wireless Module Power Sequencer

This block sits on the host side of a combined WLAN and Bluetooth radio module and drives the module's two regulator-enable lines. The host asks for each radio with a level request. The sequencer opens those requests to the module only when it is safe to do so. It watches two supply-good inputs, one for the battery rail and one for the I/O rail. It counts edges of a slow 32.768 kHz sleep clock through a two-flop synchronizer, and it counts cycles of the system clock for its long delays. All other inputs are taken to be synchronous to the system clock.

The module keeps its internal regulator on while either enable is high. For that reason, only the moment both enables go low counts as a discharge, and only that event starts the cool-down timer. The host may raise a request during the cool-down. Such a request stays pending and is applied on the first cycle the timer allows. A separate settle counter gates a bus-ready flag, which tells the host when it may start talking to the module. If the I/O rail is good while the battery rail is not, the supply order is broken. The sequencer then latches an error that only an explicit clear can remove.

Top module: `radio_power_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `wlanEn`, `btEn`, `busReady` and `seqError` are all 0.
- R2: While the regulator is on, `wlanEn` follows `wlanReq` and `btEn` follows `btReq`, each one cycle later. Dropping one request while the other stays high starts no cool-down.
- R3: When both enables fall in the same cycle, neither enable rises again for at least `COOL_CYCLES` system-clock cycles.
- R4: A request that arrives during the cool-down is applied exactly when the cool-down ends. The enable rises `COOL_CYCLES` + 1 cycles after the request inputs went low.
- R5: After both rails become good, no enable rises until `SLEEP_CYCLES` + 1 rising sleep-clock edges have passed through the synchronizer. While the sleep clock is stopped, the enables stay low.
- R6: If `ioGood` is 1 while `batGood` is 0, `seqError` rises on the next cycle, and both enables and `busReady` are 0.
- R7: `seqError` stays 1 until `errClear` is sampled high while in error. `errClear` has no effect in any other state. After a clear, a full cool-down, rail check and sleep-clock wait come before any enable.
- R8: `busReady` rises on the cycle after `SETTLE_CYCLES` + 1 consecutive system-clock edges have sampled both rails good. It is 0 on the cycle after either rail is sampled low.
- R9: If either rail drops, both enables are 0 on the next cycle. The cool-down timer restarts on every cycle a rail is low. The sleep-clock wait is repeated before the enables come back.
- R10: `busReady` stays 0 while in error, even with both rails good. It comes back on the second cycle after the clear once the settle time has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepClk | input | 1 | 32.768 kHz sleep clock, asynchronous |
| batGood | input | 1 | Battery rail good |
| ioGood | input | 1 | I/O rail good |
| errClear | input | 1 | Clears a latched sequencing error |
| wlanReq | input | 1 | Host request for the WLAN section |
| btReq | input | 1 | Host request for the Bluetooth section |
| wlanEn | output | 1 | WLAN regulator enable; low holds WLAN in reset |
| btEn | output | 1 | Bluetooth regulator enable; low holds Bluetooth in reset |
| busReady | output | 1 | Host bus accesses permitted |
| seqError | output | 1 | Supply-order error latched |

## Verification
Some rules are checked on every cycle. These are the timing floors: an enable never rises fewer than `COOL_CYCLES` low cycles after the regulator turned off, never before enough sleep-clock edges, and bus-ready never rises before the settle count. The cycle-by-cycle rules are checked too: enables drop after a rail loss, error entry and error persistence are correct, and bus-ready stays off during an error. Other behaviours show only in directed scenarios. These are the exact cycle at which a pending request takes effect, that one radio can toggle without a cool-down, that the enables stay off while the sleep clock is stopped, that a clear outside the error state is ignored, and that the full sequence restarts after a rail loss or an error clear.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_RAILS,
    ST_WAIT_SLEEP,
    ST_ON,
    ST_COOLDOWN,
    ST_ERROR
  } rpsState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic restartCool;
    logic countCool;
    logic restartSleep;
    logic countSleep;
    logic errHold;
  } rpsStrobes_t;

  // Timer status back to control
  typedef struct packed {
    logic coolDone;
    logic sleepDone;
  } rpsTimers_t;

endpackage

// File: rtl/rps_sleep_sync.sv
module rps_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepClk,
  output logic sleepRise
);

  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], sleepClk};
  end

  assign sleepRise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/rps_datapath.sv
module rps_datapath
  import rps_pkg::*;
#(
  parameter int COOL_CYCLES   = 10000,
  parameter int SETTLE_CYCLES = 150000,
  parameter int SLEEP_CYCLES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        railsOk,
  input  logic        sleepRise,
  input  rpsStrobes_t strobes,
  output rpsTimers_t  timers,
  output logic        busReady
);

  localparam int SLEEP_EDGES = SLEEP_CYCLES + 1;
  localparam int COOL_W      = $clog2(COOL_CYCLES + 1);
  localparam int SETTLE_W    = $clog2(SETTLE_CYCLES + 1);
  localparam int SLEEP_W     = $clog2(SLEEP_EDGES + 1);
  localparam logic [COOL_W-1:0]   COOL_LAST  = COOL_W'(COOL_CYCLES - 1);
  localparam logic [SETTLE_W-1:0] SETTLE_TOP = SETTLE_W'(SETTLE_CYCLES);
  localparam logic [SLEEP_W-1:0]  SLEEP_TOP  = SLEEP_W'(SLEEP_EDGES);

  logic [COOL_W-1:0]   coolCnt;
  logic [SETTLE_W-1:0] settleCnt;
  logic [SLEEP_W-1:0]  sleepCnt;

  // Cool-down: cleared on (re)start, saturates at its last count
  always_ff @(posedge clk) begin
    if (!rstN)                                       coolCnt <= '0;
    else if (strobes.restartCool)                    coolCnt <= '0;
    else if (strobes.countCool && coolCnt != COOL_LAST) coolCnt <= coolCnt + 1'b1;
  end

  // Sleep-clock edge counter for the post-rail wait
  always_ff @(posedge clk) begin
    if (!rstN)                    sleepCnt <= '0;
    else if (strobes.restartSleep) sleepCnt <= '0;
    else if (strobes.countSleep && sleepRise && sleepCnt != SLEEP_TOP)
      sleepCnt <= sleepCnt + 1'b1;
  end

  // Settle counter runs only while both rails stay good
  always_ff @(posedge clk) begin
    if (!rstN)                        settleCnt <= '0;
    else if (!railsOk)                settleCnt <= '0;
    else if (settleCnt != SETTLE_TOP) settleCnt <= settleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= railsOk && (settleCnt == SETTLE_TOP) && !strobes.errHold;
  end

  assign timers.coolDone  = (coolCnt == COOL_LAST);
  assign timers.sleepDone = (sleepCnt == SLEEP_TOP);

endmodule

// File: rtl/rps_ctrl.sv
module rps_ctrl
  import rps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        batGood,
  input  logic        ioGood,
  input  logic        errClear,
  input  logic        wlanReq,
  input  logic        btReq,
  input  rpsTimers_t  timers,
  output rpsStrobes_t strobes,
  output logic        wlanEn,
  output logic        btEn,
  output logic        seqError
);

  rpsState_t state, nxt;
  logic railLoss;
  logic setLoss;
  logic railsOk, badOrder, anyReq;

  assign railsOk  = batGood && ioGood;
  assign badOrder = ioGood && !batGood;
  assign anyReq   = wlanReq || btReq;

  always_comb begin
    nxt                  = state;
    strobes.restartCool  = 1'b0;
    strobes.restartSleep = 1'b0;
    setLoss              = 1'b0;
    if (state != ST_ERROR && badOrder) begin
      nxt = ST_ERROR;
    end else begin
      case (state)
        ST_WAIT_RAILS: begin
          if (railsOk) begin
            nxt = ST_WAIT_SLEEP;
            strobes.restartSleep = 1'b1;
          end
        end
        ST_ERROR: begin
          if (errClear) begin
            nxt = ST_COOLDOWN;
            strobes.restartCool = 1'b1;
            setLoss = 1'b1;
          end
        end
        default: begin
          if (!railsOk) begin
            nxt = ST_COOLDOWN;
            strobes.restartCool = 1'b1;
            setLoss = 1'b1;
          end else begin
            case (state)
              ST_WAIT_SLEEP: if (timers.sleepDone) nxt = ST_OFF;
              ST_OFF:        if (anyReq) nxt = ST_ON;
              ST_ON: begin
                if (!anyReq) begin
                  nxt = ST_COOLDOWN;
                  strobes.restartCool = 1'b1;
                end
              end
              ST_COOLDOWN: begin
                if (timers.coolDone)
                  nxt = railLoss ? ST_WAIT_RAILS : (anyReq ? ST_ON : ST_OFF);
              end
              default: nxt = state;
            endcase
          end
        end
      endcase
    end
  end

  assign strobes.countCool  = (state == ST_COOLDOWN);
  assign strobes.countSleep = (state == ST_WAIT_SLEEP);
  assign strobes.errHold    = (state == ST_ERROR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAIT_RAILS;
      railLoss <= 1'b0;
      wlanEn   <= 1'b0;
      btEn     <= 1'b0;
      seqError <= 1'b0;
    end else begin
      state <= nxt;
      if (setLoss)                                      railLoss <= 1'b1;
      else if (state == ST_COOLDOWN && nxt != ST_COOLDOWN) railLoss <= 1'b0;
      wlanEn   <= (nxt == ST_ON) && wlanReq;
      btEn     <= (nxt == ST_ON) && btReq;
      seqError <= (nxt == ST_ERROR);
    end
  end

endmodule

// File: rtl/radio_power_sequencer.sv
module radio_power_sequencer
  import rps_pkg::*;
#(
  parameter int COOL_CYCLES   = 10000,
  parameter int SETTLE_CYCLES = 150000,
  parameter int SLEEP_CYCLES  = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepClk,
  input  logic batGood,
  input  logic ioGood,
  input  logic errClear,
  input  logic wlanReq,
  input  logic btReq,
  output logic wlanEn,
  output logic btEn,
  output logic busReady,
  output logic seqError
);

  rpsStrobes_t strobes;
  rpsTimers_t  timers;
  logic        sleepRise;
  logic        railsOk;

  assign railsOk = batGood && ioGood;

  rps_sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sleepClk(sleepClk), .sleepRise(sleepRise)
  );

  rps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .batGood(batGood), .ioGood(ioGood),
    .errClear(errClear), .wlanReq(wlanReq), .btReq(btReq),
    .timers(timers), .strobes(strobes),
    .wlanEn(wlanEn), .btEn(btEn), .seqError(seqError)
  );

  rps_datapath #(
    .COOL_CYCLES(COOL_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES), .SLEEP_CYCLES(SLEEP_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .railsOk(railsOk), .sleepRise(sleepRise),
    .strobes(strobes), .timers(timers), .busReady(busReady)
  );

endmodule

// File: rtl/radio_power_sequencer_props.sv
module radio_power_sequencer_props #(
  parameter int COOL_CYCLES   = 10000,
  parameter int SETTLE_CYCLES = 150000,
  parameter int SLEEP_CYCLES  = 2
) (
  input logic clk,
  input logic rstN,
  input logic sleepClk,
  input logic batGood,
  input logic ioGood,
  input logic errClear,
  input logic wlanEn,
  input logic btEn,
  input logic busReady,
  input logic seqError
);

  localparam int LOW_W  = $clog2(COOL_CYCLES + 1);
  localparam int RAIL_W = $clog2(SETTLE_CYCLES + 2);
  localparam int SLP_W  = $clog2(SLEEP_CYCLES + 2);

  logic regOn, railsOk, sleepPrev;
  logic [LOW_W-1:0]  lowCnt;
  logic [RAIL_W-1:0] railCnt;
  logic [SLP_W-1:0]  slpCnt;

  assign regOn   = wlanEn || btEn;
  assign railsOk = batGood && ioGood;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt    <= LOW_W'(COOL_CYCLES);
      railCnt   <= '0;
      slpCnt    <= '0;
      sleepPrev <= 1'b0;
    end else begin
      sleepPrev <= sleepClk;
      if (regOn) lowCnt <= '0;
      else if (lowCnt != LOW_W'(COOL_CYCLES)) lowCnt <= lowCnt + 1'b1;
      if (!railsOk) railCnt <= '0;
      else if (railCnt != RAIL_W'(SETTLE_CYCLES + 1)) railCnt <= railCnt + 1'b1;
      if (!ioGood) slpCnt <= '0;
      else if (sleepClk && !sleepPrev && slpCnt != SLP_W'(SLEEP_CYCLES + 1)) slpCnt <= slpCnt + 1'b1;
    end
  end

  assert_cooldown_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regOn) |-> lowCnt >= LOW_W'(COOL_CYCLES));

  assert_sleep_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regOn) |-> slpCnt >= SLP_W'(SLEEP_CYCLES));

  assert_order_error_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ioGood && !batGood) |=> seqError);

  assert_error_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> (!wlanEn && !btEn));

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seqError && !errClear) |=> seqError);

  assert_settle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReady) |-> railCnt >= RAIL_W'(SETTLE_CYCLES));

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !railsOk |=> !busReady);

  assert_rail_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !railsOk |=> (!wlanEn && !btEn));

  assert_ready_error_R10: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> !busReady);

endmodule

bind radio_power_sequencer radio_power_sequencer_props #(
  .COOL_CYCLES(COOL_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES), .SLEEP_CYCLES(SLEEP_CYCLES)
) u_props (
  .clk(clk), .rstN(rstN), .sleepClk(sleepClk), .batGood(batGood), .ioGood(ioGood),
  .errClear(errClear), .wlanEn(wlanEn), .btEn(btEn), .busReady(busReady), .seqError(seqError)
);

// File: tb/radio_power_sequencer_test.sv
`timescale 1ns/100ps
module radio_power_sequencer_test;

  localparam int COOL   = 20;
  localparam int SETTLE = 100;
  localparam int SLEEPC = 2;
  localparam int LIMIT  = 20000;
  localparam logic [3:0] M_ALL = 4'b1111;
  localparam logic [3:0] M_EN  = 4'b1100;
  localparam logic [3:0] M_RDY = 4'b0010;
  localparam logic [3:0] M_ERR = 4'b0001;

  logic clk = 1'b0, rstN = 1'b0, sleepClk = 1'b0, sleepRun = 1'b0;
  logic batGood = 1'b0, ioGood = 1'b0, errClear = 1'b0, wlanReq = 1'b0, btReq = 1'b0;
  logic wlanEn, btEn, busReady, seqError;

  int cyc = 0, checks = 0, fails = 0, sleepEdges = 0;
  bit done = 0;

  typedef struct {
    int         cyc;
    logic [3:0] mask;
    logic [3:0] val;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  radio_power_sequencer #(
    .COOL_CYCLES(COOL), .SETTLE_CYCLES(SETTLE), .SLEEP_CYCLES(SLEEPC)
  ) uut (
    .clk(clk), .rstN(rstN), .sleepClk(sleepClk), .batGood(batGood), .ioGood(ioGood),
    .errClear(errClear), .wlanReq(wlanReq), .btReq(btReq),
    .wlanEn(wlanEn), .btEn(btEn), .busReady(busReady), .seqError(seqError)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #0.5;
    forever begin
      #11;
      if (sleepRun) sleepClk = ~sleepClk;
    end
  end
  always @(posedge sleepClk) sleepEdges <= sleepEdges + 1;

  // Driver side: expected outputs {wlanEn,btEn,busReady,seqError} n cycles ahead
  task automatic pushExp(int n, logic [3:0] mask, logic [3:0] val, string tag);
    expItem_t e;
    e.cyc = cyc + n; e.mask = mask; e.val = val; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic checkTrue(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor side: pop and compare entries due this cycle
  always @(negedge clk) begin
    logic [3:0] obs;
    obs = {wlanEn, btEn, busReady, seqError};
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].cyc == cyc) begin
        checks++;
        if ((obs & expQ[i].mask) !== (expQ[i].val & expQ[i].mask)) begin
          fails++;
          $display("FAIL %s: actual %b expected %b (mask %b) at cycle %0d",
                   expQ[i].tag, obs, expQ[i].val, expQ[i].mask, cyc);
        end
        expQ.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitEnable(int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wlanEn) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= LIMIT);
    fails++;
    $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
    finishRun();
  end

  initial begin
    int k0, kr, at, base;
    tick(3);
    pushExp(1, M_ALL, 4'b0000, "R1 in reset");
    tick(1);
    rstN = 1'b1;
    pushExp(1, M_ALL, 4'b0000, "R1 after release");

    // Good rail order, sleep clock stopped
    tick(1);
    batGood = 1'b1; wlanReq = 1'b1;
    tick(2);
    ioGood = 1'b1; k0 = cyc;
    pushExp(3, M_ERR, 4'b0000, "R6 good order no error");
    pushExp(10, M_EN, 4'b0000, "R5 no sleep edges");
    pushExp(30, M_EN, 4'b0000, "R5 no sleep edges late");
    pushExp(SETTLE, M_RDY, 4'b0000, "R8 not yet settled");
    pushExp(SETTLE + 1, M_RDY, 4'b0010, "R8 settled");
    tick(30);
    base = sleepEdges; sleepRun = 1'b1;
    waitEnable(300, at);
    checkTrue("R5 enable rose", at >= 0, at, 1);
    checkTrue("R5 sleep edges before enable", (sleepEdges - base) >= SLEEPC + 1, sleepEdges - base, SLEEPC + 1);

    // Independent enables while powered
    tick(1);
    btReq = 1'b1;
    pushExp(1, M_EN, 4'b1100, "R2 bt joins");
    tick(2);
    wlanReq = 1'b0;
    pushExp(1, M_EN, 4'b0100, "R2 wlan off alone");
    pushExp(6, M_EN, 4'b0100, "R2 no cooldown");
    tick(8);
    wlanReq = 1'b1;
    pushExp(1, M_EN, 4'b1100, "R2 wlan back at once");
    tick(3);
    errClear = 1'b1;
    pushExp(1, 4'b1101, 4'b1100, "R7 clear ignored");
    tick(1);
    errClear = 1'b0;
    pushExp(3, 4'b1101, 4'b1100, "R7 clear ignored later");
    while (cyc <= k0 + SETTLE + 3) tick(1);

    // Cool-down with pending request
    wlanReq = 1'b0; btReq = 1'b0;
    pushExp(1, M_EN, 4'b0000, "R3 both drop");
    pushExp(COOL / 2, M_EN, 4'b0000, "R3 mid cooldown");
    pushExp(COOL, M_EN, 4'b0000, "R3 last low cycle");
    pushExp(COOL + 1, M_EN, 4'b1000, "R4 pending applied");
    pushExp(COOL + 1, M_RDY, 4'b0010, "R8 ready holds");
    tick(3);
    wlanReq = 1'b1;
    tick(COOL + 5);

    // Rail loss
    batGood = 1'b0; ioGood = 1'b0;
    pushExp(1, M_ALL, 4'b0000, "R9 rails lost");
    tick(10);
    batGood = 1'b1; ioGood = 1'b1; kr = cyc;
    pushExp(COOL, M_EN, 4'b0000, "R9 cooldown after restore");
    base = sleepEdges;
    waitEnable(400, at);
    checkTrue("R9 re-enable not early", at >= kr + COOL + 2, at, kr + COOL + 2);
    checkTrue("R5 sleep wait repeated", (sleepEdges - base) >= SLEEPC + 1, sleepEdges - base, SLEEPC + 1);

    // Supply-order error
    tick(1);
    batGood = 1'b0;
    pushExp(1, M_ALL, 4'b0001, "R6 order error");
    tick(2);
    batGood = 1'b1;
    pushExp(20, M_ALL, 4'b0001, "R7 error sticky");
    pushExp(SETTLE + 10, M_ALL, 4'b0001, "R10 ready held in error");
    tick(SETTLE + 12);
    errClear = 1'b1;
    pushExp(1, 4'b0011, 4'b0000, "R7 cleared");
    pushExp(2, M_RDY, 4'b0010, "R10 ready after clear");
    pushExp(COOL, M_EN, 4'b0000, "R7 cooldown after clear");
    tick(1);
    errClear = 1'b0;
    waitEnable(400, at);
    checkTrue("R7 sequence restarts", at >= 0, at, 1);

    while (expQ.size() > 0) tick(1);
    tick(2);
    finishRun();
  end

endmodule